// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs an external successive-approximation converter through a timed conversion. Enabling the converter starts a reference settle period. A start command then runs an input-select phase followed by a conversion phase. All three phases are timed by counting ticks of the serial bus clock, which arrive as a one-cycle enable pulse on `bus_tick`. If sync mode is requested, the block waits in an armed state until an external trigger pin is seen high, and only then starts the input-select phase.

Software writes a single 16-bit control word and polls a 16-bit data word until its valid flag is set. When a conversion finishes, the block also emits a one-cycle done pulse for an interrupt controller. The analog side is a behavioural stub. It returns the 10-bit level presented for the selected channel, and that level is captured at the end of the conversion phase.

Top module: `adc_seq`

## Requirements
- R1: After reset, `data_reg` reads 0x0000, `done_pulse` is low and the converter is disabled.
- R2: A control write that sets enable (bit 0) from the disabled state starts a settle period of SETTLE_TICKS (60) bus ticks. If the same write also sets start (bit 1), the result becomes valid 60+51+102 = 213 ticks after the write edge.
- R3: A start written while the converter is enabled and idle runs input select for 51 ticks and then conversion for 102 ticks. The valid flag rises exactly 153 ticks after the write edge and not before.
- R4: Any start command clears the valid flag in the cycle after the write, while the result field keeps its old value. A start issued during a conversion restarts the sequence with the newly written channel mask.
- R5: The channel mask (control bits 15:8) selects the channel given by its lowest set bit, and the result equals that channel's input level. An all-zero mask yields a result of 0.
- R6: With sync enabled (control bit 2), the block waits as long as `sync_pin` is low. Input select begins at the first clock edge on which `sync_pin` is sampled high, and the result is valid 153 ticks after that edge.
- R7: `done_pulse` is high for exactly one cycle, in the same cycle in which the valid flag first reads 1.
- R8: A control write with enable clear aborts any phase in progress and clears the valid flag, and no done pulse follows. Enabling again repeats the full settle period.
- R9: Phase counters advance only in cycles where `bus_tick` is high. Cycles without a tick do not shorten the sequence.
- R10: The data word holds the valid flag in bit 15 and the result in bits 9:0, and reads zero in bits 14:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_tick | input | 1 | One-cycle pulse per serial bus clock period |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: bit0 enable, bit1 start, bit2 sync, bits15:8 channel mask |
| sync_pin | input | 1 | External conversion trigger, synchronous to clk |
| chan_levels | input | NCH*RES_W (80) | Behavioural analog level per channel, channel k at bits k*10 +: 10 |
| data_reg | output | 16 | Data word: bit15 valid, bits9:0 result |
| done_pulse | output | 1 | One-cycle conversion-complete event |

## Verification
The channel sweep walks a one-hot mask over all eight channels, each driven with a distinct level, so a wrong channel index or wrong bit slice shows up as a wrong result. Multi-bit and empty masks separate lowest-bit priority from other selection rules. Latency is measured edge by edge for five cases: start from idle, start together with enable, sync-gated start, a start stalled by missing ticks, and a restart during a conversion. Each case has its own expected count, so an off-by-one in any phase, a skipped settle or an ignored trigger changes a measured number. A disable during a conversion checks that the abort leaves no valid flag and no done pulse behind.

// File: rtl/adc_seq_pkg.sv
// Shared definitions for the ADC conversion sequencer.
// Assumes a 16-bit control word and a 16-bit data word.
package adc_seq_pkg;
    localparam int EN_BIT    = 0;
    localparam int START_BIT = 1;
    localparam int SYNC_BIT  = 2;
    localparam int MASK_LSB  = 8;
    localparam int VALID_BIT = 15;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SETTLE,
        ST_READY,
        ST_ARMED,
        ST_SELECT,
        ST_CONVERT
    } seq_state_t;
endpackage

// File: rtl/adc_chan_pick.sv
// Picks the lowest set bit of a channel mask and returns its index.
// Assumes NCH >= 2; any_set is low for an empty mask.
module adc_chan_pick #(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    output logic [IW-1:0]  idx,
    output logic           any_set
);
    // Priority scan from the top down so the lowest set bit wins.
    always_comb begin
        idx     = '0;
        any_set = |mask;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (mask[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/adc_stub.sv
// Behavioural converter model: captures the selected channel level on sample.
// Assumes levels are static during a conversion; empty selection gives zero.
module adc_stub #(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    localparam int IW = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic [IW-1:0]        idx,
    input  logic                 any_set,
    input  logic [NCH*RES_W-1:0] levels,
    output logic [RES_W-1:0]     code
);
    // Hold the last converted code; update only at the end of conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)       code <= '0;
        else if (sample)  code <= any_set ? levels[idx*RES_W +: RES_W] : '0;
    end
endmodule

// File: rtl/adc_seq_fsm.sv
// Phase sequencer: settle, optional trigger wait, input select, convert.
// Assumes bus_tick is a single-cycle enable and sync_pin is synchronous.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH          = 8,
    parameter int SETTLE_TICKS = 60,
    parameter int SEL_TICKS    = 51,
    parameter int CONV_TICKS   = 102,
    localparam int MAXT = (SETTLE_TICKS > CONV_TICKS) ?
                          ((SETTLE_TICKS > SEL_TICKS) ? SETTLE_TICKS : SEL_TICKS) :
                          ((CONV_TICKS > SEL_TICKS) ? CONV_TICKS : SEL_TICKS),
    localparam int CW = $clog2(MAXT) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_tick,
    input  logic           ctrl_we,
    input  logic [15:0]    ctrl_wdata,
    input  logic           sync_pin,
    output logic [NCH-1:0] mask_q,
    output logic           sample,
    output logic           valid,
    output logic           done
);
    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          pend;
    logic          sync_q;

    logic wr_en, wr_start, wr_sync, take_write;
    assign wr_en    = ctrl_wdata[EN_BIT];
    assign wr_start = ctrl_wdata[START_BIT];
    assign wr_sync  = ctrl_wdata[SYNC_BIT];

    // A write overrides the phase logic when it disables, starts, or powers up.
    assign take_write = ctrl_we && (!wr_en || wr_start || state == ST_OFF);

    // End of conversion: last tick of the convert phase with no overriding write.
    assign sample = !take_write && state == ST_CONVERT && bus_tick &&
                    cnt == CW'(CONV_TICKS - 1);

    // Main sequencer: register writes first, then phase timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            cnt    <= '0;
            pend   <= 1'b0;
            sync_q <= 1'b0;
            mask_q <= '0;
            valid  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (take_write) begin
                cnt <= '0;
                if (!wr_en) begin
                    state <= ST_OFF;
                    pend  <= 1'b0;
                    valid <= 1'b0;
                end else begin
                    if (wr_start) begin
                        mask_q <= ctrl_wdata[MASK_LSB +: NCH];
                        sync_q <= wr_sync;
                        valid  <= 1'b0;
                    end
                    if (state == ST_OFF) begin
                        state <= ST_SETTLE;
                        pend  <= wr_start;
                    end else if (state == ST_SETTLE) begin
                        cnt  <= cnt;
                        pend <= 1'b1;
                    end else begin
                        state <= wr_sync ? ST_ARMED : ST_SELECT;
                    end
                end
            end else begin
                case (state)
                    ST_SETTLE: if (bus_tick) begin
                        if (cnt == CW'(SETTLE_TICKS - 1)) begin
                            cnt  <= '0;
                            pend <= 1'b0;
                            if (pend) state <= sync_q ? ST_ARMED : ST_SELECT;
                            else      state <= ST_READY;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ARMED: if (sync_pin) begin
                        state <= ST_SELECT;
                        cnt   <= '0;
                    end
                    ST_SELECT: if (bus_tick) begin
                        if (cnt == CW'(SEL_TICKS - 1)) begin
                            cnt   <= '0;
                            state <= ST_CONVERT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_CONVERT: if (bus_tick) begin
                        if (sample) begin
                            cnt   <= '0;
                            state <= ST_READY;
                            valid <= 1'b1;
                            done  <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> valid);
    // R4
    start_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[START_BIT]) |=> !valid);
    // R8
    off_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!valid && !done));
    // R6
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !sync_pin && !ctrl_we) |=> state == ST_ARMED);
    // R9
    no_tick_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_tick && !ctrl_we && state != ST_ARMED) |=> $stable(cnt));
endmodule

// File: rtl/adc_seq.sv
// Top of the ADC conversion sequencer: control decode, channel pick,
// converter stub and data word assembly. Assumes NCH <= 8, RES_W <= 15.
module adc_seq #(
    parameter int NCH          = 8,
    parameter int RES_W        = 10,
    parameter int SETTLE_TICKS = 60,
    parameter int SEL_TICKS    = 51,
    parameter int CONV_TICKS   = 102
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_tick,
    input  logic                 ctrl_we,
    input  logic [15:0]          ctrl_wdata,
    input  logic                 sync_pin,
    input  logic [NCH*RES_W-1:0] chan_levels,
    output logic [15:0]          data_reg,
    output logic                 done_pulse
);
    import adc_seq_pkg::*;
    localparam int IW = $clog2(NCH);

    logic [NCH-1:0]   mask_q;
    logic [IW-1:0]    idx;
    logic             any_set;
    logic             sample;
    logic             valid;
    logic [RES_W-1:0] code;

    adc_seq_fsm #(
        .NCH(NCH), .SETTLE_TICKS(SETTLE_TICKS),
        .SEL_TICKS(SEL_TICKS), .CONV_TICKS(CONV_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .sync_pin(sync_pin),
        .mask_q(mask_q), .sample(sample), .valid(valid), .done(done_pulse)
    );

    adc_chan_pick #(.NCH(NCH)) u_pick (
        .mask(mask_q), .idx(idx), .any_set(any_set)
    );

    adc_stub #(.NCH(NCH), .RES_W(RES_W)) u_stub (
        .clk(clk), .rst_n(rst_n), .sample(sample), .idx(idx),
        .any_set(any_set), .levels(chan_levels), .code(code)
    );

    // Data word: valid flag on top, result in the low bits, rest zero.
    always_comb begin
        data_reg            = '0;
        data_reg[RES_W-1:0] = code;
        data_reg[VALID_BIT] = valid;
    end

    // R10
    data_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_reg[14:RES_W] == '0);
endmodule

// File: tb/adc_seq_test.sv
module adc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tick = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        sync_pin = 1'b0;
    logic [79:0] chan_levels;
    logic [15:0] data_reg;
    logic        done_pulse;

    int total = 0;
    int bad = 0;
    int n;
    logic saw_done;

    always #5 clk = ~clk;

    adc_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .sync_pin(sync_pin), .chan_levels(chan_levels),
        .data_reg(data_reg), .done_pulse(done_pulse)
    );

    function automatic int lvl(int k);
        return 100 * k + 37;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // Count edges until valid reads 1; note whether done was high then.
    task automatic wait_valid(output int cnt, output logic dn);
        cnt = 0;
        dn = 1'b0;
        while (cnt < 400) begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
            if (data_reg[15]) begin
                dn = done_pulse;
                break;
            end
        end
    endtask

    function automatic logic [15:0] ctl(input logic [7:0] m, input bit st, input bit sy);
        return {m, 5'b0, sy, st, 1'b1};
    endfunction

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) chan_levels[k*10 +: 10] = 10'(lvl(k));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(data_reg == 16'h0 && !done_pulse, "R1 reset", data_reg, 0);
        rst_n = 1'b1;

        // R2 enable + start together: settle then select/convert
        wr(ctl(8'h08, 1, 0));
        chk(!data_reg[15], "R4 valid low after start", data_reg[15], 0);
        wait_valid(n, saw_done);
        chk(n == 213, "R2 latency", n, 213);
        chk(data_reg[9:0] == 10'(lvl(3)), "R5 channel 3", data_reg[9:0], lvl(3));
        chk(saw_done, "R7 done with valid", saw_done, 1);
        chk(data_reg[14:10] == 0, "R10 zero bits", data_reg[14:10], 0);
        @(negedge clk);
        chk(!done_pulse && data_reg[15], "R7 single cycle", done_pulse, 0);

        // R3 R5 one-hot channel sweep
        for (int k = 0; k < 8; k++) begin
            logic [9:0] prev;
            prev = data_reg[9:0];
            wr(ctl(8'(1 << k), 1, 0));
            chk(!data_reg[15] && data_reg[9:0] == prev, "R4 old result kept", data_reg, prev);
            wait_valid(n, saw_done);
            chk(n == 153, "R3 latency", n, 153);
            chk(data_reg[9:0] == 10'(lvl(k)), "R5 one-hot result", data_reg[9:0], lvl(k));
        end

        // R5 multi-bit and empty masks
        begin
            logic [7:0] masks [4] = '{8'b1011_0100, 8'hF0, 8'hFF, 8'h00};
            int exps [4];
            exps = '{lvl(2), lvl(4), lvl(0), 0};
            for (int i = 0; i < 4; i++) begin
                wr(ctl(masks[i], 1, 0));
                wait_valid(n, saw_done);
                chk(data_reg[9:0] == 10'(exps[i]), "R5 lowest bit", data_reg[9:0], exps[i]);
            end
        end

        // R6 sync-gated start
        wr(ctl(8'h20, 1, 1));
        repeat (300) @(negedge clk);
        chk(!data_reg[15], "R6 waits for trigger", data_reg[15], 0);
        sync_pin = 1'b1;
        wait_valid(n, saw_done);
        sync_pin = 1'b0;
        chk(n == 154, "R6 latency from trigger", n, 154);
        chk(data_reg[9:0] == 10'(lvl(5)), "R6 result", data_reg[9:0], lvl(5));

        // R9 missing ticks stall the sequence
        bus_tick = 1'b0;
        wr(ctl(8'h40, 1, 0));
        repeat (200) @(negedge clk);
        chk(!data_reg[15], "R9 no progress without tick", data_reg[15], 0);
        bus_tick = 1'b1;
        wait_valid(n, saw_done);
        chk(n == 153, "R9 latency after ticks resume", n, 153);

        // R4 restart during conversion uses new mask
        wr(ctl(8'h01, 1, 0));
        repeat (80) @(negedge clk);
        wr(ctl(8'h80, 1, 0));
        wait_valid(n, saw_done);
        chk(n == 153, "R4 restart latency", n, 153);
        chk(data_reg[9:0] == 10'(lvl(7)), "R4 restart result", data_reg[9:0], lvl(7));

        // R8 disable aborts, then full settle again
        wr(ctl(8'h02, 1, 0));
        repeat (100) @(negedge clk);
        wr(16'h0000);
        saw_done = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done_pulse || data_reg[15]) saw_done = 1'b1;
        end
        chk(!saw_done, "R8 no result after abort", saw_done, 0);
        wr(ctl(8'h02, 1, 0));
        wait_valid(n, saw_done);
        chk(n == 213, "R8 settle repeated", n, 213);
        chk(data_reg[9:0] == 10'(lvl(1)), "R8 result", data_reg[9:0], lvl(1));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule